// File: doc/BRIEF.md
# Lane Suspend-Clock Gating and Clock-Request Controller

This block sits beside one data lane of a serial link physical layer. It decides whether the lane's suspend clock may be stopped and produces the clock-request signal that the lane passes on to the next lane in a chain. A 2-bit mode register sets two things independently. The upper bit allows the suspend clock to be gated. The lower bit makes the clock-request track the lane's conditions; when it is clear, the clock-request is held at a programmed force level.

Gating is allowed only while the lane sits in its deepest power state and no TX common-mode change is pending. When the clock-request is dynamic, it is raised if the lane is outside the deepest state, if the suspend clock is needed, or if the previous lane in the chain is requesting. Both outputs come straight from flops, so the clock-enable feeding an integrated clock gate changes only on a clock edge.

Top module: `lane_sclk_gate_ctl`

## Requirements
- R1: While reset is high and on the first edge after it, the mode register is 00 and both `sclk_en` and `lane_req` are 1.
- R2: The mode register loads `mode_wdata` on an edge where `mode_we` is 1. On any other edge it keeps its value, so the outputs stay as the stored mode dictates.
- R3: `sclk_en` is 0 only when, on the previous edge, mode bit 1 was 1, `pwr_state` equalled the deepest-state code 3, and `cm_chg_req` was 0. Otherwise it is 1.
- R4: A `cm_chg_req` of 1 sampled on an edge makes `sclk_en` 1 after that edge, even in gating mode in the deepest state.
- R5: When mode bit 0 is 1, `lane_req` after an edge equals (`pwr_state` != 3) OR `sclk_need` OR `prev_lane_req`, sampled on that edge.
- R6: When mode bit 0 is 0, `lane_req` after an edge equals `force_lvl` sampled on that edge, whatever the power state, need and chain inputs are.
- R7: Both outputs are registered. A change on any input between edges leaves the outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Suspend-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load strobe for the mode register |
| mode_wdata | input | 2 | Mode value: bit 1 allows gating, bit 0 selects a dynamic clock-request |
| pwr_state | input | 2 | Lane power state; code 3 is the deepest state |
| sclk_need | input | 1 | The lane needs its suspend clock |
| cm_chg_req | input | 1 | A TX common-mode change is pending |
| prev_lane_req | input | 1 | Clock-request from the previous lane in the chain |
| force_lvl | input | 1 | Level used for `lane_req` when it is not dynamic |
| sclk_en | output | 1 | Enable for the suspend-clock gate cell |
| lane_req | output | 1 | Clock-request sent to the next lane |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known value at each rising edge once reset is released. They also assume that the mode register changes only through the write strobe. The bench drives all inputs half a period away from the rising edge and sets every input to 0 or 1 before reset is released. It holds each input pattern stable across the edges it is checked on, so each output can be traced to a single sampled set of inputs.

// File: rtl/lane_sclk_gate_pkg.sv
package lane_sclk_gate_pkg;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned GATE_BIT = 1;
  localparam int unsigned DYN_BIT = 0;

  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    logic gate_allow;
    logic req_dynamic;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input mode_t m);
    mode_dec_t d;
    d.gate_allow  = m[GATE_BIT];
    d.req_dynamic = m[DYN_BIT];
    return d;
  endfunction
endpackage

// File: rtl/lane_sclk_mode_reg.sv
module lane_sclk_mode_reg
  import lane_sclk_gate_pkg::*;
#(
  parameter mode_t RST_MODE = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  mode_t wdata,
  output mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RST_MODE;
    end else if (we) begin
      mode_q <= wdata;
    end
  end
endmodule

// File: rtl/lane_sclk_gate_fsm.sv
module lane_sclk_gate_fsm #(
  parameter bit EN_RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_allow,
  input  logic in_deep,
  input  logic cm_chg_req,
  output logic sclk_en_q
);
  logic may_gate;

  always_comb begin
    may_gate = gate_allow && in_deep && !cm_chg_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_en_q <= EN_RST_VAL;
    end else begin
      sclk_en_q <= !may_gate;
    end
  end
endmodule

// File: rtl/lane_sclk_req_gen.sv
module lane_sclk_req_gen #(
  parameter bit REQ_RST_VAL = 1'b1,
  parameter bit CHAIN_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_dynamic,
  input  logic in_deep,
  input  logic sclk_need,
  input  logic prev_lane_req,
  input  logic force_lvl,
  output logic lane_req_q
);
  logic chain_in;
  logic dyn_req;
  logic req_nxt;

  generate
    if (CHAIN_EN) begin : g_chain
      assign chain_in = prev_lane_req;
    end else begin : g_no_chain
      assign chain_in = 1'b0;
    end
  endgenerate

  always_comb begin
    dyn_req = !in_deep || sclk_need || chain_in;
    req_nxt = req_dynamic ? dyn_req : force_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_req_q <= REQ_RST_VAL;
    end else begin
      lane_req_q <= req_nxt;
    end
  end
endmodule

// File: rtl/lane_sclk_gate_ctl.sv
module lane_sclk_gate_ctl
  import lane_sclk_gate_pkg::*;
#(
  parameter int unsigned PS_W       = 2,
  parameter int unsigned DEEP_STATE = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_we,
  input  logic [1:0]      mode_wdata,
  input  logic [PS_W-1:0] pwr_state,
  input  logic            sclk_need,
  input  logic            cm_chg_req,
  input  logic            prev_lane_req,
  input  logic            force_lvl,
  output logic            sclk_en,
  output logic            lane_req
);
  localparam logic [PS_W-1:0] DEEP_CODE = PS_W'(DEEP_STATE);

  mode_t     mode_q;
  mode_dec_t mdec;
  logic      in_deep;

  assign mdec    = decode_mode(mode_q);
  assign in_deep = (pwr_state == DEEP_CODE);

  lane_sclk_mode_reg #(.RST_MODE(2'b00)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .we     (mode_we),
    .wdata  (mode_wdata),
    .mode_q (mode_q)
  );

  lane_sclk_gate_fsm #(.EN_RST_VAL(1'b1)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .gate_allow (mdec.gate_allow),
    .in_deep    (in_deep),
    .cm_chg_req (cm_chg_req),
    .sclk_en_q  (sclk_en)
  );

  lane_sclk_req_gen #(.REQ_RST_VAL(1'b1), .CHAIN_EN(1'b1)) u_req (
    .clk           (clk),
    .rst           (rst),
    .req_dynamic   (mdec.req_dynamic),
    .in_deep       (in_deep),
    .sclk_need     (sclk_need),
    .prev_lane_req (prev_lane_req),
    .force_lvl     (force_lvl),
    .lane_req_q    (lane_req)
  );
endmodule

// File: rtl/lane_sclk_gate_chk.sv
module lane_sclk_gate_chk #(
  parameter int unsigned PS_W       = 2,
  parameter int unsigned DEEP_STATE = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            mode_we,
  input logic [1:0]      mode_q,
  input logic [PS_W-1:0] pwr_state,
  input logic            sclk_need,
  input logic            cm_chg_req,
  input logic            prev_lane_req,
  input logic            force_lvl,
  input logic            sclk_en,
  input logic            lane_req
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state just after a reset edge
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      p_reset_vals_r1: assert (mode_q == 2'b00 && sclk_en && lane_req)
        else $error("reset values wrong");
    end
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_we)) |-> $stable(mode_q));

  p_gate_cond_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !sclk_en) |->
      ($past(mode_q[1]) && $past(pwr_state) == PS_W'(DEEP_STATE) && !$past(cm_chg_req)));

  p_cm_wake_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cm_chg_req)) |-> sclk_en);

  p_dyn_req_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q[0])) |->
      (lane_req == ($past(pwr_state) != PS_W'(DEEP_STATE) || $past(sclk_need) || $past(prev_lane_req))));

  p_forced_req_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_q[0])) |-> (lane_req == $past(force_lvl)));
endmodule

bind lane_sclk_gate_ctl lane_sclk_gate_chk #(.PS_W(PS_W), .DEEP_STATE(DEEP_STATE)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_we       (mode_we),
  .mode_q        (mode_q),
  .pwr_state     (pwr_state),
  .sclk_need     (sclk_need),
  .cm_chg_req    (cm_chg_req),
  .prev_lane_req (prev_lane_req),
  .force_lvl     (force_lvl),
  .sclk_en       (sclk_en),
  .lane_req      (lane_req)
);

// File: tb/lane_sclk_gate_ctl_tb.sv
module lane_sclk_gate_ctl_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic mode_we;
  logic [1:0] mode_wdata;
  logic [1:0] pwr_state;
  logic sclk_need, cm_chg_req, prev_lane_req, force_lvl;
  logic sclk_en, lane_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lane_sclk_gate_ctl dut_i (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .pwr_state(pwr_state), .sclk_need(sclk_need), .cm_chg_req(cm_chg_req),
    .prev_lane_req(prev_lane_req), .force_lvl(force_lvl),
    .sclk_en(sclk_en), .lane_req(lane_req)
  );

  // fields: [9:8] mode [7:6] pwr_state [5] need [4] cm [3] prev [2] force [1] exp_en [0] exp_req
  localparam int NV = 13;
  localparam logic [9:0] VEC [NV] = '{
    {2'b00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 forced low
    {2'b00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R6 forced high
    {2'b01, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 all quiet
    {2'b01, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 not deep
    {2'b01, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 need
    {2'b01, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 chain
    {2'b10, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 gated
    {2'b10, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 cm blocks
    {2'b10, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 not deep
    {2'b11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 R5 both
    {2'b11, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 chain while gated
    {2'b11, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 shallow
    {2'b11, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}  // R4 cm wakes
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [1:0] ps, input logic nd, input logic cm,
                        input logic pv, input logic fv);
    pwr_state = ps; sclk_need = nd; cm_chg_req = cm; prev_lane_req = pv; force_lvl = fv;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_we = 1'b0; mode_wdata = 2'b11;
    set_in(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 en in reset", sclk_en, 1'b1);
    check("R1 req in reset", lane_req, 1'b1);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // mode 00 after reset: no gating, forced low
    check("R1 mode00 en", sclk_en, 1'b1);
    check("R1 mode00 req", lane_req, 1'b0);

    for (int i = 0; i < NV; i++) begin
      mode_we = 1'b1; mode_wdata = VEC[i][9:8];
      set_in(VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      @(posedge clk); @(negedge clk);
      mode_we = 1'b0;
      @(posedge clk); @(negedge clk);
      check($sformatf("R3/R4 vec%0d en", i), sclk_en, VEC[i][1]);
      check($sformatf("R5/R6 vec%0d req", i), lane_req, VEC[i][0]);
    end

    // R2: write data present without strobe is ignored (mode stays 11)
    mode_we = 1'b1; mode_wdata = 2'b11; set_in(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    mode_we = 1'b0; mode_wdata = 2'b00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 hold en", sclk_en, 1'b0);
    check("R2 hold req", lane_req, 1'b0);

    // R4: cm request wakes on the next edge
    cm_chg_req = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 wake", sclk_en, 1'b1);
    cm_chg_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 regate", sclk_en, 1'b0);

    // R7: mid-cycle input change does not reach outputs before an edge
    @(posedge clk); #1;
    set_in(2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    #2;
    check("R7 en stable", sclk_en, 1'b0);
    check("R7 req stable", lane_req, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R7 en after edge", sclk_en, 1'b1);
    check("R7 req after edge", lane_req, 1'b1);

    // R1: reset mid-run returns to defaults
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 rerun en", sclk_en, 1'b1);
    set_in(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 rerun mode00 en", sclk_en, 1'b1);
    check("R1 rerun mode00 req", lane_req, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule